// File: doc/BRIEF.md
# Sectored Four-Way Cache Tag Directory

This block keeps the tags and coherence states for a four-way set-associative cache. Each way of a set holds one 64-byte sector. A sector is two 32-byte lines. The sector carries one tag and belongs to one per-set replacement tree. Each of its two lines carries its own 2-bit MESI state. The block stores no data.

A lookup takes a physical address. One cycle later it returns:
- whether the line hit;
- whether only the sector matched while the addressed line is Invalid;
- the matching way and the state of the addressed line;
- the octet and dword-half position of the request;
- a victim way and a write-back flag, for use when nothing matched.

The update port installs or changes a sector after a fill and marks that way as most recently used. The maintenance port reads or writes any sector's tag and both line states, addressed by set and way.

After reset, a sequencer spends one cycle on each set to clear it. While it runs, the block reports busy and drops every request.

Top module: `sect_dir`

## Requirements
- R1: Address fields are decoded as follows. Byte offset is bits [4:0]. `lk_octet` = bits [4:3] and `lk_half` = bit 2. Bit 5 picks line 1 (1) or line 0 (0) of the sector. The next log2(SETS) bits are the set index. The remaining upper bits are the tag.
- R2: `lk_valid` is high for exactly the one cycle that follows a lookup request accepted while not busy. All lookup outputs are meaningful in that cycle.
- R3: A way takes part in matching only when at least one of its two lines is not Invalid (encoding I=0, S=1, E=2, M=3). The lookup hits when such a way's tag is equal to the request tag and the addressed line is not Invalid. On a hit, `lk_way` is that way and `lk_state` is that line's state.
- R4: When the tag matches but the addressed line is Invalid, the result is `lk_sector_hit`=1 with `lk_hit`=0. `lk_way` then names the matching way and `lk_state` is 0. On a full miss, `lk_way` and `lk_state` are both 0.
- R5: The victim is the lowest-numbered way whose two lines are both Invalid. If no way qualifies, the per-set 3-bit tree chooses. Bit 0 selects the pair: 0 means ways 0/1, 1 means ways 2/3. Bit 1 then picks way 1 over way 0 when set. Bit 2 picks way 3 over way 2 when set.
- R6: The tree is touched on every lookup hit and on every update-port write, and the touched way becomes most recently used. Touching way 0 sets b0=1 and b1=1. Way 1 sets b0=1 and b1=0. Way 2 sets b0=0 and b2=1. Way 3 sets b0=0 and b2=0. When an update write and a lookup hit hit the same set in one cycle, the update write decides the tree.
- R7: `lk_wb` is 1 only when no tag matched and the victim sector holds a Modified line.
- R8: A maintenance read returns the tag and both line states of the addressed set and way with `mt_rvalid` high one cycle after the request.
- R9: A maintenance write issued in the same cycle as a lookup request is visible in that lookup's result. When the update port and a maintenance write target the same set and way in one cycle, the maintenance write is the one stored.
- R10: After reset, `busy` stays high for exactly SETS cycles while every line state is cleared to Invalid and every tree to 0. During that time, lookups, updates and maintenance requests are dropped.
- R11: An update-port write stores the given tag and both line states into the addressed set and way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | output | 1 | Clearing sequence running; requests dropped |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Physical address to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Addressed line present |
| lk_sector_hit | output | 1 | Tag matched, addressed line Invalid |
| lk_way | output | 2 | Matching way |
| lk_state | output | 2 | MESI state of the addressed line |
| lk_victim | output | 2 | Way to replace on a miss |
| lk_wb | output | 1 | Victim sector needs write-back |
| lk_octet | output | 2 | Octet index of the request |
| lk_half | output | 1 | Upper (1) or lower (0) dword of the octet |
| up_en | input | 1 | Update write enable |
| up_set | input | log2(SETS) | Update set index |
| up_way | input | 2 | Update way |
| up_tag | input | TAG_W | Tag to install |
| up_st0 | input | 2 | State of line 0 |
| up_st1 | input | 2 | State of line 1 |
| mt_en | input | 1 | Maintenance access request |
| mt_we | input | 1 | Maintenance access is a write |
| mt_set | input | log2(SETS) | Maintenance set index |
| mt_way | input | 2 | Maintenance way |
| mt_wtag | input | TAG_W | Maintenance write tag |
| mt_wst0 | input | 2 | Maintenance write state, line 0 |
| mt_wst1 | input | 2 | Maintenance write state, line 1 |
| mt_rvalid | output | 1 | Maintenance read data valid |
| mt_rtag | output | TAG_W | Maintenance read tag |
| mt_rd_st0 | output | 2 | Maintenance read state, line 0 |
| mt_rd_st1 | output | 2 | Maintenance read state, line 1 |

## Verification
A maintenance write and a lookup can land in the same cycle and touch the same set and way. Likewise, an update write and a maintenance write can collide on one entry.

The bench provokes the first case by rewriting a sector into a Modified state in the very cycle a missing lookup to that set is issued. It judges the case by whether the returned victim and write-back flag already reflect the new states.

The second case drives both write ports at one entry. A maintenance read-back must then show the maintenance values.

// File: rtl/dir_pkg.sv
package dir_pkg;

    localparam int WAYS = 4;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef struct packed {
        logic       line;
        logic [1:0] octet;
        logic       half;
    } pos_t;

    // victim selected by the 3-bit tree
    function automatic logic [1:0] tree_pick(input logic [2:0] t);
        if (t[0]) return t[2] ? 2'd3 : 2'd2;
        else      return t[1] ? 2'd1 : 2'd0;
    endfunction

    // mark a way most recently used
    function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n = t;
        case (w)
            2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
            2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
            2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
            default: begin n[0] = 1'b0; n[2] = 1'b0; end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dir_way_store.sv
module dir_way_store #(
    parameter int SETS  = 512,
    parameter int TAG_W = 17,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_idx,
    input  logic             up_we,
    input  logic [SET_W-1:0] up_idx,
    input  logic [TAG_W-1:0] up_tag,
    input  logic [1:0]       up_st0,
    input  logic [1:0]       up_st1,
    input  logic             mt_we,
    input  logic [SET_W-1:0] mt_idx,
    input  logic [TAG_W-1:0] mt_tag,
    input  logic [1:0]       mt_st0,
    input  logic [1:0]       mt_st1,
    input  logic [SET_W-1:0] ra_idx,
    output logic [TAG_W-1:0] ra_tag,
    output logic [1:0]       ra_st0,
    output logic [1:0]       ra_st1,
    input  logic [SET_W-1:0] rb_idx,
    output logic [TAG_W-1:0] rb_tag,
    output logic [1:0]       rb_st0,
    output logic [1:0]       rb_st1
);
    import dir_pkg::*;

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [1:0]       st0_mem [SETS];
    logic [1:0]       st1_mem [SETS];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            tag_mem[clr_idx] <= '0;
            st0_mem[clr_idx] <= ST_I;
            st1_mem[clr_idx] <= ST_I;
        end else begin
            if (up_we) begin
                tag_mem[up_idx] <= up_tag;
                st0_mem[up_idx] <= up_st0;
                st1_mem[up_idx] <= up_st1;
            end
            // maintenance write placed last so it wins a collision
            if (mt_we) begin
                tag_mem[mt_idx] <= mt_tag;
                st0_mem[mt_idx] <= mt_st0;
                st1_mem[mt_idx] <= mt_st1;
            end
        end
    end

    assign ra_tag = tag_mem[ra_idx];
    assign ra_st0 = st0_mem[ra_idx];
    assign ra_st1 = st1_mem[ra_idx];
    assign rb_tag = tag_mem[rb_idx];
    assign rb_st0 = st0_mem[rb_idx];
    assign rb_st1 = st1_mem[rb_idx];

endmodule

// File: rtl/dir_match.sv
module dir_match #(
    parameter int TAG_W = 17
) (
    input  logic [3:0][TAG_W-1:0] tags,
    input  logic [3:0][1:0]       st0,
    input  logic [3:0][1:0]       st1,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic                  req_line,
    input  logic [2:0]            tree,
    output logic                  hit,
    output logic                  sec_hit,
    output logic [1:0]            way,
    output logic [1:0]            state,
    output logic [1:0]            victim,
    output logic                  wb
);
    import dir_pkg::*;

    logic [WAYS-1:0]      occ;
    logic [WAYS-1:0]      match;
    logic [WAYS-1:0][1:0] line_st;
    logic                 any_match;
    logic                 any_free;
    logic [1:0]           match_idx;
    logic [1:0]           free_idx;

    always_comb begin
        any_match = 1'b0;
        any_free  = 1'b0;
        match_idx = 2'd0;
        free_idx  = 2'd0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            occ[w]     = (st0[w] != ST_I) || (st1[w] != ST_I);
            match[w]   = occ[w] && (tags[w] == req_tag);
            line_st[w] = req_line ? st1[w] : st0[w];
            // descending walk leaves the lowest index selected
            if (match[w]) begin
                any_match = 1'b1;
                match_idx = 2'(w);
            end
            if (!occ[w]) begin
                any_free = 1'b1;
                free_idx = 2'(w);
            end
        end
        way     = any_match ? match_idx : 2'd0;
        state   = any_match ? line_st[match_idx] : ST_I;
        hit     = any_match && (line_st[match_idx] != ST_I);
        sec_hit = any_match && (line_st[match_idx] == ST_I);
        victim  = any_free ? free_idx : tree_pick(tree);
        wb      = !any_match && ((st0[victim] == ST_M) || (st1[victim] == ST_M));
    end

endmodule

// File: rtl/sect_dir.sv
module sect_dir #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 512,
    parameter int SET_W  = $clog2(SETS),
    parameter int TAG_W  = ADDR_W - 6 - SET_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic              busy,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic              lk_sector_hit,
    output logic [1:0]        lk_way,
    output logic [1:0]        lk_state,
    output logic [1:0]        lk_victim,
    output logic              lk_wb,
    output logic [1:0]        lk_octet,
    output logic              lk_half,
    input  logic              up_en,
    input  logic [SET_W-1:0]  up_set,
    input  logic [1:0]        up_way,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [1:0]        up_st0,
    input  logic [1:0]        up_st1,
    input  logic              mt_en,
    input  logic              mt_we,
    input  logic [SET_W-1:0]  mt_set,
    input  logic [1:0]        mt_way,
    input  logic [TAG_W-1:0]  mt_wtag,
    input  logic [1:0]        mt_wst0,
    input  logic [1:0]        mt_wst1,
    output logic              mt_rvalid,
    output logic [TAG_W-1:0]  mt_rtag,
    output logic [1:0]        mt_rd_st0,
    output logic [1:0]        mt_rd_st1
);
    import dir_pkg::*;

    localparam int SET_LO = 6;

    // clearing sequencer
    logic             busy_q;
    logic [SET_W-1:0] clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            clr_q  <= '0;
        end else if (busy_q) begin
            if (clr_q == SET_W'(SETS - 1)) busy_q <= 1'b0;
            clr_q <= clr_q + 1'b1;
        end
    end
    assign busy = busy_q;

    logic up_ok, mt_wr_ok, mt_rd_ok;
    assign up_ok    = up_en && !busy_q;
    assign mt_wr_ok = mt_en && mt_we && !busy_q;
    assign mt_rd_ok = mt_en && !mt_we && !busy_q;

    // lookup request stage
    logic             lk_v_q;
    logic [SET_W-1:0] set_q;
    logic [TAG_W-1:0] tag_q;
    pos_t             pos_q;
    logic [1:0]       unused_addr_bits;

    assign unused_addr_bits = lk_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_v_q <= 1'b0;
        end else begin
            lk_v_q <= lk_req && !busy_q;
        end
        if (lk_req) begin
            set_q       <= lk_addr[SET_LO +: SET_W];
            tag_q       <= lk_addr[ADDR_W-1 -: TAG_W];
            pos_q.line  <= lk_addr[5];
            pos_q.octet <= lk_addr[4:3];
            pos_q.half  <= lk_addr[2];
        end
    end

    // maintenance read stage
    logic             mt_rv_q;
    logic [SET_W-1:0] mt_set_q;
    logic [1:0]       mt_way_q;

    always_ff @(posedge clk) begin
        if (rst) mt_rv_q <= 1'b0;
        else     mt_rv_q <= mt_rd_ok;
        if (mt_rd_ok) begin
            mt_set_q <= mt_set;
            mt_way_q <= mt_way;
        end
    end

    // per-way storage
    logic [3:0][TAG_W-1:0] ra_tag, rb_tag;
    logic [3:0][1:0]       ra_st0, ra_st1, rb_st0, rb_st1;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        dir_way_store #(.SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W)) u_store (
            .clk     (clk),
            .clr_en  (busy_q),
            .clr_idx (clr_q),
            .up_we   (up_ok && (up_way == 2'(g))),
            .up_idx  (up_set),
            .up_tag  (up_tag),
            .up_st0  (up_st0),
            .up_st1  (up_st1),
            .mt_we   (mt_wr_ok && (mt_way == 2'(g))),
            .mt_idx  (mt_set),
            .mt_tag  (mt_wtag),
            .mt_st0  (mt_wst0),
            .mt_st1  (mt_wst1),
            .ra_idx  (set_q),
            .ra_tag  (ra_tag[g]),
            .ra_st0  (ra_st0[g]),
            .ra_st1  (ra_st1[g]),
            .rb_idx  (mt_set_q),
            .rb_tag  (rb_tag[g]),
            .rb_st0  (rb_st0[g]),
            .rb_st1  (rb_st1[g])
        );
    end

    // replacement trees
    logic [2:0] tree_mem [SETS];
    logic [2:0] tree_rd;
    assign tree_rd = tree_mem[set_q];

    logic       m_hit, m_sec;
    logic [1:0] m_way, m_state, m_victim;
    logic       m_wb;

    dir_match #(.TAG_W(TAG_W)) u_match (
        .tags     (ra_tag),
        .st0      (ra_st0),
        .st1      (ra_st1),
        .req_tag  (tag_q),
        .req_line (pos_q.line),
        .tree     (tree_rd),
        .hit      (m_hit),
        .sec_hit  (m_sec),
        .way      (m_way),
        .state    (m_state),
        .victim   (m_victim),
        .wb       (m_wb)
    );

    always_ff @(posedge clk) begin
        if (busy_q) begin
            tree_mem[clr_q] <= 3'b000;
        end else begin
            if (lk_v_q && m_hit)
                tree_mem[set_q] <= tree_touch(tree_rd, m_way);
            // update write placed last so it decides a same-set collision
            if (up_ok)
                tree_mem[up_set] <= tree_touch(tree_mem[up_set], up_way);
        end
    end

    assign lk_valid      = lk_v_q;
    assign lk_hit        = m_hit;
    assign lk_sector_hit = m_sec;
    assign lk_way        = m_way;
    assign lk_state      = m_state;
    assign lk_victim     = m_victim;
    assign lk_wb         = m_wb;
    assign lk_octet      = pos_q.octet;
    assign lk_half       = pos_q.half;

    assign mt_rvalid = mt_rv_q;
    assign mt_rtag   = rb_tag[mt_way_q];
    assign mt_rd_st0 = rb_st0[mt_way_q];
    assign mt_rd_st1 = rb_st1[mt_way_q];

endmodule

// File: rtl/sect_dir_chk.sv
module sect_dir_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       lk_req,
    input logic       lk_valid,
    input logic       lk_hit,
    input logic       lk_sector_hit,
    input logic [1:0] lk_state,
    input logic       lk_wb,
    input logic       mt_en,
    input logic       mt_we,
    input logic       mt_rvalid
);

    // R2
    result_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $past(lk_req));

    // R3
    hit_line_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |-> (lk_state != 2'b00));

    // R4
    hit_sector_excl_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> !(lk_hit && lk_sector_hit));

    // R4
    sector_hit_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_sector_hit) |-> (lk_state == 2'b00));

    // R7
    wb_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_wb) |-> (!lk_hit && !lk_sector_hit));

    // R8
    maint_read_timing_chk: assert property (@(posedge clk) disable iff (rst)
        mt_rvalid |-> $past(mt_en && !mt_we));

    // R10
    busy_blocks_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !lk_valid);

    // R10
    busy_never_returns_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);

endmodule

bind sect_dir sect_dir_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .lk_req        (lk_req),
    .lk_valid      (lk_valid),
    .lk_hit        (lk_hit),
    .lk_sector_hit (lk_sector_hit),
    .lk_state      (lk_state),
    .lk_wb         (lk_wb),
    .mt_en         (mt_en),
    .mt_we         (mt_we),
    .mt_rvalid     (mt_rvalid)
);

// File: tb/sim_sect_dir.sv
module sim_sect_dir;

    localparam int ADDR_W = 32;
    localparam int SETS   = 512;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - 6 - SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              busy;
    logic              lk_req = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_valid, lk_hit, lk_sector_hit, lk_wb, lk_half;
    logic [1:0]        lk_way, lk_state, lk_victim, lk_octet;
    logic              up_en = 1'b0;
    logic [SET_W-1:0]  up_set = '0;
    logic [1:0]        up_way = '0;
    logic [TAG_W-1:0]  up_tag = '0;
    logic [1:0]        up_st0 = '0, up_st1 = '0;
    logic              mt_en = 1'b0, mt_we = 1'b0;
    logic [SET_W-1:0]  mt_set = '0;
    logic [1:0]        mt_way = '0;
    logic [TAG_W-1:0]  mt_wtag = '0;
    logic [1:0]        mt_wst0 = '0, mt_wst1 = '0;
    logic              mt_rvalid;
    logic [TAG_W-1:0]  mt_rtag;
    logic [1:0]        mt_rd_st0, mt_rd_st1;

    always #10 clk = ~clk;

    sect_dir #(.ADDR_W(ADDR_W), .SETS(SETS)) u0 (.*);

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
    localparam logic [TAG_W-1:0] TA = 17'h00A11, TB = 17'h00B22, TC = 17'h00C33,
                                 TD = 17'h00D44, TX = 17'h1F0F0;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] set;
        logic             line;
        logic [1:0]       oct;
        logic             half;
        logic             hit;
        logic             sec;
        logic [1:0]       way;
        logic [1:0]       st;
        logic [1:0]       vic;
        logic             wb;
    } vec_t;

    // set 5: way0 A {M,I}, way1 B {S,E}, way2 C {I,I}, way3 D {E,I}
    localparam vec_t TBL [9] = '{
        '{TA, 9'd5, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, M, 2'd2, 1'b0},
        '{TA, 9'd5, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, I, 2'd2, 1'b0},
        '{TB, 9'd5, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, S, 2'd2, 1'b0},
        '{TB, 9'd5, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 2'd1, E, 2'd2, 1'b0},
        '{TC, 9'd5, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, I, 2'd2, 1'b0},
        '{TD, 9'd5, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, I, 2'd2, 1'b0},
        '{TD, 9'd5, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd3, E, 2'd2, 1'b0},
        '{TX, 9'd5, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, I, 2'd2, 1'b0},
        '{TA, 9'd6, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, I, 2'd0, 1'b0}
    };

    function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s,
                                             input logic ln, input logic [1:0] o, input logic h);
        return {t, s, ln, o, h, 2'b01};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [SET_W-1:0] s, input logic [1:0] w,
                             input logic [TAG_W-1:0] t, input logic [1:0] a, input logic [1:0] b);
        @(negedge clk);
        up_en = 1'b1; up_set = s; up_way = w; up_tag = t; up_st0 = a; up_st1 = b;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    // issues a lookup; returns at the negedge where the result is valid
    task automatic do_lookup(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic maint_read(input logic [SET_W-1:0] s, input logic [1:0] w);
        @(negedge clk);
        mt_en = 1'b1; mt_we = 1'b0; mt_set = s; mt_way = w;
        @(negedge clk);
        mt_en = 1'b0;
    endtask

    task automatic reset_and_wait(output int n);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // requests during clearing must be dropped (R10)
        up_en = 1'b1; up_set = 9'd9; up_way = 2'd0; up_tag = TA; up_st0 = M; up_st1 = M;
        lk_req = 1'b1; lk_addr = mk(TA, 9'd9, 1'b0, 2'd0, 1'b0);
        n = 0;
        while (busy && n < SETS + 20) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                up_en = 1'b0; lk_req = 1'b0;
                check("R10 valid during busy", {31'd0, lk_valid}, 32'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        check("R10 busy in reset", {31'd0, busy}, 32'd1);
        reset_and_wait(n);
        check("R10 busy length", n, SETS);

        // R10: update issued during busy was dropped
        do_lookup(mk(TA, 9'd9, 1'b0, 2'd0, 1'b0));
        check("R10 dropped update", {30'd0, lk_hit, lk_sector_hit}, 32'd0);

        // R11: load set 5 through the update port
        do_update(9'd5, 2'd0, TA, M, I);
        do_update(9'd5, 2'd1, TB, S, E);
        do_update(9'd5, 2'd2, TC, I, I);
        do_update(9'd5, 2'd3, TD, E, I);

        // R1 R3 R4 R5 R11 table
        foreach (TBL[i]) begin
            do_lookup(mk(TBL[i].tag, TBL[i].set, TBL[i].line, TBL[i].oct, TBL[i].half));
            check($sformatf("R1 R2 R3 R4 R5 R11 vector %0d", i),
                  {19'd0, lk_valid, lk_hit, lk_sector_hit, lk_way, lk_state, lk_victim, lk_wb, lk_octet, lk_half},
                  {19'd0, 1'b1, TBL[i].hit, TBL[i].sec, TBL[i].way, TBL[i].st, TBL[i].vic, TBL[i].wb,
                   TBL[i].oct, TBL[i].half});
            @(negedge clk);
            check("R2 single-cycle valid", {31'd0, lk_valid}, 32'd0);
        end

        // R6 R5: tree behaviour in set 7
        do_update(9'd7, 2'd0, TA, S, S);
        do_update(9'd7, 2'd1, TB, S, S);
        do_update(9'd7, 2'd2, TC, S, S);
        do_update(9'd7, 2'd3, TD, S, S);
        do_lookup(mk(TX, 9'd7, 1'b0, 2'd0, 1'b0));
        check("R6 victim after fills", {30'd0, lk_victim}, 32'd0);
        do_lookup(mk(TA, 9'd7, 1'b0, 2'd0, 1'b0));
        check("R3 hit way0", {29'd0, lk_hit, lk_way}, {29'd0, 1'b1, 2'd0});
        do_lookup(mk(TX, 9'd7, 1'b0, 2'd0, 1'b0));
        check("R6 victim after hit0", {30'd0, lk_victim}, 32'd2);
        do_lookup(mk(TC, 9'd7, 1'b1, 2'd0, 1'b0));
        do_lookup(mk(TX, 9'd7, 1'b0, 2'd0, 1'b0));
        check("R6 victim after hit2", {30'd0, lk_victim}, 32'd1);

        // R9 R7: maintenance write in the lookup's own cycle
        @(negedge clk);
        lk_req = 1'b1; lk_addr = mk(TX, 9'd7, 1'b0, 2'd0, 1'b0);
        mt_en = 1'b1; mt_we = 1'b1; mt_set = 9'd7; mt_way = 2'd1;
        mt_wtag = 17'h01234; mt_wst0 = M; mt_wst1 = S;
        @(negedge clk);
        lk_req = 1'b0; mt_en = 1'b0; mt_we = 1'b0;
        check("R9 R7 forwarded victim/wb", {29'd0, lk_victim, lk_wb}, {29'd0, 2'd1, 1'b1});

        // R8 maintenance read-back
        maint_read(9'd7, 2'd1);
        check("R8 read", {11'd0, mt_rvalid, mt_rtag, mt_rd_st0, mt_rd_st1},
              {11'd0, 1'b1, 17'h01234, M, S});

        // R9 collision of update and maintenance write
        @(negedge clk);
        up_en = 1'b1; up_set = 9'd7; up_way = 2'd3; up_tag = 17'h00111; up_st0 = S; up_st1 = S;
        mt_en = 1'b1; mt_we = 1'b1; mt_set = 9'd7; mt_way = 2'd3;
        mt_wtag = 17'h00222; mt_wst0 = E; mt_wst1 = I;
        @(negedge clk);
        up_en = 1'b0; mt_en = 1'b0; mt_we = 1'b0;
        maint_read(9'd7, 2'd3);
        check("R9 maint wins", {11'd0, mt_rvalid, mt_rtag, mt_rd_st0, mt_rd_st1},
              {11'd0, 1'b1, 17'h00222, E, I});

        // R10: second reset clears states
        reset_and_wait(n);
        check("R10 busy length again", n, SETS);
        do_lookup(mk(TA, 9'd5, 1'b0, 2'd0, 1'b0));
        check("R10 cleared after reset", {29'd0, lk_hit, lk_sector_hit, lk_wb}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule